// File: doc/BRIEF.md
# Multi-Mode Stereo Serial Audio Receiver

This block takes a stereo PCM stream delivered on a serial data line and turns it into parallel left/right sample pairs. The bit clock, the framing (left/right) clock, an optional word clock and the data line are all asynchronous to the system clock. They are brought into the system domain by synchronizer flops, and the active bit-clock edge is found by comparing successive synchronized samples. Every decision about framing is therefore made once per detected bit, and the data, framing and word-clock levels that are used come from that same bit.

Two static mode pins choose one of four framings. In three of them the framing clock places the most significant bit: on the edge bit itself, one bit later, or sixteen bits later. The fourth framing takes its timing from the rising word clock. A polarity pin chooses whether bits are taken on the rising or the falling bit-clock edge. A static length input sets the field width, from 4 to 16 bits. The bit clock may run without gaps, with the right field following the left one directly, or it may come in bursts that idle high or low between fields. Each received channel is left-aligned in a 16-bit word, and a pair is presented once the right channel of a frame is complete.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted, `valid_o` is 0 and both `left_o` and `right_o` are zero.
- R2: With `mode_i` = 2'b00, the MSB is the bit at which the framing clock has changed level. A high framing clock marks the left channel and a low one the right channel.
- R3: With `mode_i` = 2'b01, the MSB is the bit that follows the one at which the framing clock changed level.
- R4: With `mode_i` = 2'b10, the MSB is the 17th bit counted from the framing-clock edge bit (offset 16), so a 16-bit field ends on the last bit of a 32-bit half frame.
- R5: With `mode_i` = 2'b11, the MSB is the first bit at which the word clock is sampled high after being sampled low. Framing-clock edges alone start no field, and the framing-clock level at the MSB selects the channel.
- R6: With `mode_i` other than 2'b11, the word clock has no effect on the received samples.
- R7: With `bclk_inv_i` = 0, bits are taken on rising bit-clock edges. With `bclk_inv_i` = 1, bits are taken on falling edges.
- R8: A field holds `field_len_i` bits (4 to 16), MSB first. The field is output left-aligned, with its MSB in bit 15 and all lower unused bits zero.
- R9: Fields may follow each other with no gap, including 32-bit frames of two 16-bit channels.
- R10: The bit clock may stop between fields at either level without affecting the received data.
- R11: `valid_o` is high for exactly one system clock, one cycle after the final bit of a right field that follows a completed left field. `left_o` and `right_o` change only with that pulse. A right field with no preceding left field produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, may be gated |
| lrclk_i | input | 1 | Framing clock, high = left channel |
| wclk_i | input | 1 | Word clock, used only in word-clock mode |
| sdata_i | input | 1 | Serial data, MSB first, two's complement |
| mode_i | input | 2 | Framing select (00, 01, 10, 11 as in R2 to R5) |
| bclk_inv_i | input | 1 | Sampling edge select, 1 = falling edge |
| field_len_i | input | 5 | Bits per channel field, 4 to 16 |
| left_o | output | 16 | Left sample, left-aligned |
| right_o | output | 16 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new pair |

## Verification
A stale or off-by-one position counter, or a wrong word-clock history bit, makes the first affected pair carry a word that is shifted by a bit or more. Filler ones placed around every field make any such shift show as wrong high bits or nonzero low bits. A channel flag or pairing flag that is left set wrongly shows up as a missing pulse, or as an extra pulse for a lone right field, at the end of that frame. A stuck busy bit or index corrupts the very next field, so every such fault reaches the ports within one frame of the stimulus.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned MIN_LEN  = 4;

  typedef enum logic [1:0] {
    FRM_EDGE     = 2'b00,
    FRM_EDGE_DLY = 2'b01,
    FRM_RIGHT    = 2'b10,
    FRM_WORDCLK  = 2'b11
  } frame_mode_e;
endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= '0;
          else        pipe_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[g] <= '0;
          else        pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/asrx_framer.sv
module asrx_framer
  import asrx_pkg::*;
#(
  parameter int unsigned RJ_OFFSET = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_s,
  input  logic       lr_s,
  input  logic       wc_s,
  input  logic [1:0] mode_i,
  input  logic       bclk_inv_i,
  output logic       bit_stb_o,
  output logic       start_o
);
  localparam int unsigned POS_W = $clog2(RJ_OFFSET + 2);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  frame_mode_e     mode;
  logic            bclk_prev_q;
  logic            lr_prev_q, lr_prev_d;
  logic            wc_prev_q, wc_prev_d;
  logic [POS_W-1:0] pos_q, pos_d, pos_now, msb_pos;
  logic            lr_edge, wc_rise;

  assign mode = frame_mode_e'(mode_i);

  // active edge of the synchronized bit clock
  assign bit_stb_o = bclk_inv_i ? (bclk_prev_q & ~bclk_s)
                                : (~bclk_prev_q & bclk_s);

  always_comb begin
    case (mode)
      FRM_EDGE_DLY: msb_pos = POS_W'(1);
      FRM_RIGHT:    msb_pos = POS_W'(RJ_OFFSET);
      default:      msb_pos = '0;
    endcase
  end

  always_comb begin
    lr_edge = lr_s ^ lr_prev_q;
    wc_rise = wc_s & ~wc_prev_q;
    if (lr_edge)             pos_now = '0;
    else if (pos_q == POS_MAX) pos_now = POS_MAX;
    else                     pos_now = pos_q + 1'b1;

    if (mode == FRM_WORDCLK) start_o = bit_stb_o & wc_rise;
    else                     start_o = bit_stb_o & (pos_now == msb_pos);

    lr_prev_d = lr_prev_q;
    wc_prev_d = wc_prev_q;
    pos_d     = pos_q;
    if (bit_stb_o) begin
      lr_prev_d = lr_s;
      wc_prev_d = wc_s;
      pos_d     = pos_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
      lr_prev_q   <= 1'b0;
      wc_prev_q   <= 1'b0;
      pos_q       <= POS_MAX;
    end else begin
      bclk_prev_q <= bclk_s;
      lr_prev_q   <= lr_prev_d;
      wc_prev_q   <= wc_prev_d;
      pos_q       <= pos_d;
    end
  end
endmodule

// File: rtl/asrx_assembler.sv
module asrx_assembler
  import asrx_pkg::*;
#(
  parameter int unsigned WORD_W = SAMPLE_W,
  parameter int unsigned LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb_i,
  input  logic              start_i,
  input  logic              lr_i,
  input  logic              sd_i,
  input  logic [LEN_W-1:0]  field_len_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  localparam int unsigned IDX_W = $clog2(WORD_W);

  logic              busy_q, busy_d;
  logic              chan_q, chan_d;
  logic [LEN_W-1:0]  idx_q, idx_d, cur_idx, len_eff;
  logic [WORD_W-1:0] word_q, word_d, word_set;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              have_left_q, have_left_d;
  logic [WORD_W-1:0] left_q, left_d, right_q, right_d;
  logic              valid_q, valid_d;
  logic              take, last, cur_chan;
  logic [IDX_W-1:0]  bit_pos;

  always_comb begin
    if (field_len_i < LEN_W'(MIN_LEN))     len_eff = LEN_W'(MIN_LEN);
    else if (field_len_i > LEN_W'(WORD_W)) len_eff = LEN_W'(WORD_W);
    else                                   len_eff = field_len_i;
  end

  always_comb begin
    take     = bit_stb_i & (start_i | busy_q);
    cur_chan = start_i ? lr_i : chan_q;
    cur_idx  = start_i ? '0 : idx_q;
    word_set = start_i ? '0 : word_q;
    bit_pos  = IDX_W'(WORD_W - 1) - cur_idx[IDX_W-1:0];
    word_set[bit_pos] = sd_i;
    last     = take & (LEN_W'(cur_idx + 1'b1) == len_eff);

    busy_d      = busy_q;
    chan_d      = chan_q;
    idx_d       = idx_q;
    word_d      = word_q;
    hold_d      = hold_q;
    have_left_d = have_left_q;
    left_d      = left_q;
    right_d     = right_q;
    valid_d     = 1'b0;

    if (take) begin
      busy_d = ~last;
      chan_d = cur_chan;
      idx_d  = LEN_W'(cur_idx + 1'b1);
      word_d = word_set;
    end

    if (last) begin
      if (cur_chan) begin
        hold_d      = word_set;
        have_left_d = 1'b1;
      end else if (have_left_q) begin
        left_d      = hold_q;
        right_d     = word_set;
        valid_d     = 1'b1;
        have_left_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      chan_q      <= 1'b0;
      idx_q       <= '0;
      word_q      <= '0;
      hold_q      <= '0;
      have_left_q <= 1'b0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
    end else begin
      busy_q      <= busy_d;
      chan_q      <= chan_d;
      idx_q       <= idx_d;
      word_q      <= word_d;
      hold_q      <= hold_d;
      have_left_q <= have_left_d;
      left_q      <= left_d;
      right_q     <= right_d;
      valid_q     <= valid_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int unsigned WORD_W      = SAMPLE_W,
  parameter int unsigned LEN_W       = $clog2(WORD_W + 1),
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RJ_OFFSET   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  input  logic [1:0]        mode_i,
  input  logic              bclk_inv_i,
  input  logic [LEN_W-1:0]  field_len_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic [3:0] pins_s;
  logic       bit_stb, start;

  asrx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({bclk_i, lrclk_i, wclk_i, sdata_i}),
    .q_o   (pins_s)
  );

  asrx_framer #(.RJ_OFFSET(RJ_OFFSET)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_s     (pins_s[3]),
    .lr_s       (pins_s[2]),
    .wc_s       (pins_s[1]),
    .mode_i     (mode_i),
    .bclk_inv_i (bclk_inv_i),
    .bit_stb_o  (bit_stb),
    .start_o    (start)
  );

  asrx_assembler #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb_i   (bit_stb),
    .start_i     (start),
    .lr_i        (pins_s[2]),
    .sd_i        (pins_s[0]),
    .field_len_i (field_len_i),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o)
  );
endmodule

// File: rtl/asrx_checker.sv
module asrx_checker #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LEN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LEN_W-1:0]  field_len_i,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              valid_o
);
  logic [LEN_W-1:0]  len_c;
  logic [WORD_W-1:0] fill_mask;

  always_comb begin
    if (field_len_i < LEN_W'(4))           len_c = LEN_W'(4);
    else if (field_len_i > LEN_W'(WORD_W)) len_c = LEN_W'(WORD_W);
    else                                   len_c = field_len_i;
    fill_mask = {WORD_W{1'b1}} >> len_c;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!valid_o && left_o == '0 && right_o == '0));

  // R11
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R11
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R8
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (((left_o | right_o) & fill_mask) == '0));
endmodule

bind audio_serial_rx asrx_checker #(.WORD_W(WORD_W), .LEN_W(LEN_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .field_len_i (field_len_i),
  .left_o      (left_o),
  .right_o     (right_o),
  .valid_o     (valid_o)
);

// File: tb/audio_serial_rx_tb_top.sv
module audio_serial_rx_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bclk, lrclk, wclk, sdata;
  logic [1:0]  mode;
  logic        pol;
  logic [4:0]  flen;
  logic [15:0] left_o, right_o;
  logic        valid_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  logic [31:0] exp_q [$];

  audio_serial_rx dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_i      (bclk),
    .lrclk_i     (lrclk),
    .wclk_i      (wclk),
    .sdata_i     (sdata),
    .mode_i      (mode),
    .bclk_inv_i  (pol),
    .field_len_i (flen),
    .left_o      (left_o),
    .right_o     (right_o),
    .valid_o     (valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] align(input logic [15:0] d, input int len);
    logic [31:0] m;
    m = (32'd1 << len) - 1;
    return 16'((32'(d) & m) << (16 - len));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compare every produced pair against the scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check(cur_req, {left_o, right_o}, 32'hxxxx_xxxx);
      end else begin
        check(cur_req, {left_o, right_o}, exp_q.pop_front());
      end
    end
  end

  task automatic drive_bit(input logic lr, input logic wc, input logic sd);
    @(negedge clk);
    bclk  = pol;
    lrclk = lr;
    wclk  = wc;
    sdata = sd;
    repeat (4) @(negedge clk);
    bclk = ~pol;
    repeat (3) @(negedge clk);
  endtask

  // half frame: hbits bit periods, MSB at position dpos, filler ones elsewhere
  task automatic drive_half(input logic lr, input logic [15:0] d, input int hbits,
                            input int dpos, input int gap);
    int len;
    len = int'(flen);
    for (int p = 0; p < hbits; p++) begin
      logic sd, wc;
      sd = 1'b1;
      if (p >= dpos && p < dpos + len) sd = d[len - 1 - (p - dpos)];
      if (mode == 2'b11) wc = (p >= dpos && p < dpos + 2);
      else               wc = (p == 3);
      drive_bit(lr, wc, sd);
    end
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r,
                            input int hbits, input int dpos, input int gap);
    exp_q.push_back({align(l, int'(flen)), align(r, int'(flen))});
    drive_half(1'b1, l, hbits, dpos, gap);
    drive_half(1'b0, r, hbits, dpos, gap);
  endtask

  task automatic configure(input logic [1:0] m, input logic p, input int len);
    @(negedge clk);
    rst_n = 1'b0;
    mode  = m;
    pol   = p;
    flen  = 5'(len);
    bclk  = p;
    lrclk = 1'b0;
    wclk  = 1'b0;
    sdata = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic drain(input string req);
    repeat (40) @(negedge clk);
    check({req, " drained"}, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; wclk = 1'b0; sdata = 1'b0;
    mode = 2'b00; pol = 1'b0; flen = 5'd16;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(valid_o), 32'd0);
    check("R1 outputs", {left_o, right_o}, 32'd0);

    // R2, R6, R9: edge-aligned, gapless 32-bit frames, word clock toggling
    configure(2'b00, 1'b0, 16);
    cur_req = "R2/R6/R9";
    send_frame(16'h8001, 16'h7FFE, 16, 0, 0);
    send_frame(16'hA5C3, 16'h1234, 16, 0, 0);
    send_frame(16'h0000, 16'hFFFF, 16, 0, 0);
    drain("R2");

    // R3: one-bit delayed MSB, packed and 32-bit halves
    configure(2'b01, 1'b0, 16);
    cur_req = "R3/R9";
    send_frame(16'hC0DE, 16'h4321, 17, 1, 0);
    send_frame(16'h8000, 16'h0001, 32, 1, 0);
    drain("R3");

    // R4: right-justified, 64 bit periods per frame
    configure(2'b10, 1'b0, 16);
    cur_req = "R4";
    send_frame(16'hBEEF, 16'h5A5A, 32, 16, 0);
    send_frame(16'h0F0F, 16'hF0F1, 32, 16, 0);
    drain("R4");

    // R5, R11: word-clock triggered; a lone right field first gives no pair
    configure(2'b11, 1'b0, 16);
    cur_req = "R5/R11";
    drive_half(1'b0, 16'h1111, 20, 2, 0);
    send_frame(16'h9876, 16'h0F1E, 20, 2, 0);
    send_frame(16'h7001, 16'h8FFE, 20, 2, 0);
    drain("R5");

    // R7, R10: falling-edge sampling, bursts idling low between fields
    configure(2'b00, 1'b1, 8);
    cur_req = "R7/R10";
    send_frame(16'h00A7, 16'h0059, 16, 0, 20);
    send_frame(16'h0080, 16'h007F, 16, 0, 20);
    drain("R7");

    // R8: shortest field, falling edge, delayed MSB
    configure(2'b01, 1'b1, 4);
    cur_req = "R8";
    send_frame(16'h0009, 16'h0006, 8, 1, 10);
    send_frame(16'h000F, 16'h0001, 8, 1, 0);
    drain("R8");

    // R8: 10-bit field right-justified position
    configure(2'b10, 1'b0, 10);
    cur_req = "R8/R4";
    send_frame(16'h02AB, 16'h0155, 32, 16, 0);
    drain("R8 len10");

    // R10: bursts idling high between fields, rising edge sampling
    configure(2'b10, 1'b0, 16);
    cur_req = "R10";
    send_frame(16'h3C3C, 16'hC3C3, 32, 16, 30);
    send_frame(16'hFFFF, 16'h8000, 32, 16, 30);
    drain("R10");

    // R6: word clock pulses in mode 01 with 12-bit fields
    configure(2'b01, 1'b0, 12);
    cur_req = "R6";
    send_frame(16'h0ABC, 16'h0DEF, 16, 1, 0);
    drain("R6");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule